// File: doc/BRIEF.md
# Idempotent Sharer Invalidation Handler

This block sits on the cache side of a directory coherence scheme and answers invalidations that the directory forwards to a sharer. It keeps a small state table, one entry per tracked line. Each entry holds a two-bit coherence state and a data word. Every invalidation is answered with an acknowledgement one cycle later. The block is built so that a retransmitted invalidation always yields the same state change and the same acknowledgement as the first one. A requester whose acknowledgement was lost in the network can therefore resend its request and still complete.

A shared copy is dropped at once and answered with a plain acknowledgement. A line that holds the only modified copy is handled differently: its data is not thrown away. The line enters a waiting-for-permission state, keeps the data, and sends it inside the acknowledgement. It stays there until an explicit permission message arrives. Any repeat of the invalidation during the wait sends the same data again. A local fill port lets the surrounding cache install a line as shared or modified when the entry is free.

Top module: `shinv_handler`

## Requirements
- R1: After reset every line is invalid and `ack_valid` is low.
- R2: An invalidation (`msg_kind`=0) for a shared line makes it invalid. One cycle later it produces a plain acknowledgement: `ack_valid`=1, `ack_has_data`=0, `ack_data`=0, with `ack_line` and `ack_tag` equal to the message's line and tag.
- R3: An invalidation for an invalid line leaves it invalid and produces the same plain acknowledgement as R2. A repeated invalidation is therefore answered exactly like the original.
- R4: An invalidation for a modified line moves it to the waiting-for-permission state and keeps its data. One cycle later it produces an acknowledgement with `ack_has_data`=1 and `ack_data` equal to the stored word.
- R5: An invalidation for a line waiting for permission leaves it waiting and produces a data acknowledgement identical to the first one.
- R6: A permission message (`msg_kind`=1) for a line waiting for permission makes it invalid and discards its data. No acknowledgement is produced. A later invalidation of that line gets a plain acknowledgement.
- R7: A permission message for a line in any other state is ignored. It produces no acknowledgement and does not change the line's state or data.
- R8: A fill (`fill_dirty`=0 installs shared, 1 installs modified with `fill_data`) takes effect only when the line is invalid. A fill is dropped when a message targets the same line in the same cycle.
- R9: `ack_valid` is high exactly in the cycle after an invalidation is accepted, and never at any other time.
- R10: Lines are independent: a message or fill for one line leaves every other line unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Incoming message present this cycle |
| msg_kind | input | 1 | 0 = invalidation, 1 = invalidate permission |
| msg_line | input | IDX_W (3) | Line index the message targets |
| msg_tag | input | TAG_W (6) | Transaction tag, echoed in the acknowledgement |
| fill_valid | input | 1 | Local install request |
| fill_line | input | IDX_W (3) | Line index to install |
| fill_dirty | input | 1 | 0 = install shared, 1 = install modified |
| fill_data | input | DATA_W (32) | Data word for the installed line |
| ack_valid | output | 1 | Acknowledgement present |
| ack_line | output | IDX_W (3) | Line index being acknowledged |
| ack_tag | output | TAG_W (6) | Tag of the acknowledged invalidation |
| ack_has_data | output | 1 | Acknowledgement carries modified data |
| ack_data | output | DATA_W (32) | Retained data, zero for a plain acknowledgement |

## Verification
The bench repeats invalidations to lines in every state, back to back.
- A design that dropped modified data on the first invalidation would answer the duplicate with a plain or zero-data acknowledgement.
- A design that went silent on an invalid line would leave the scoreboard holding an unmatched entry.
- Permission messages are sent to lines that are not waiting. A design that honoured them would release a modified line, and the next invalidation would come back without data.
- A fill is sent to a waiting line, and another fill collides with a message to the same line. A design that let either one through would change the later acknowledgement's data or type.

// File: rtl/shinv_pkg.sv
package shinv_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_MOD = 2'd2,
    LS_MWP = 2'd3   // modified data kept, waiting for permission
  } line_st_e;

  typedef enum logic {
    MK_INVAL  = 1'b0,
    MK_PERMIT = 1'b1
  } msg_kind_e;

  // State reached by a line that receives a message.
  function automatic line_st_e f_next_on_msg(line_st_e cur, msg_kind_e k);
    line_st_e nxt;
    nxt = cur;
    if (k == MK_INVAL) begin
      case (cur)
        LS_SHR:  nxt = LS_INV;
        LS_MOD:  nxt = LS_MWP;
        default: nxt = cur;     // LS_INV and LS_MWP are fixed points
      endcase
    end else begin
      if (cur == LS_MWP) nxt = LS_INV;
    end
    return nxt;
  endfunction

  // Only invalidations are answered.
  function automatic logic f_acks(msg_kind_e k);
    return k == MK_INVAL;
  endfunction

  // Whether the answer to an invalidation carries the line's data.
  function automatic logic f_ack_carries_data(line_st_e cur);
    return (cur == LS_MOD) || (cur == LS_MWP);
  endfunction

  // Whether a local fill may install into a line.
  function automatic logic f_fill_allowed(line_st_e cur, logic msg_same_line);
    return (cur == LS_INV) && !msg_same_line;
  endfunction

endpackage

// File: rtl/shinv_line.sv
module shinv_line
  import shinv_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_hit,
  input  msg_kind_e         msg_kind,
  input  logic              fill_hit,
  input  logic              fill_dirty,
  input  logic [DATA_W-1:0] fill_data,
  output line_st_e          st_o,
  output logic [DATA_W-1:0] data_o
);

  line_st_e          st_q;
  logic [DATA_W-1:0] data_q;
  line_st_e          st_after_msg;
  logic              fill_take;

  assign st_after_msg = f_next_on_msg(st_q, msg_kind);
  assign fill_take    = fill_hit && f_fill_allowed(st_q, msg_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= LS_INV;
      data_q <= '0;
    end else if (msg_hit) begin
      st_q <= st_after_msg;
      if (st_after_msg == LS_INV) data_q <= '0;
    end else if (fill_take) begin
      st_q   <= fill_dirty ? LS_MOD : LS_SHR;
      data_q <= fill_data;
    end
  end

  assign st_o   = st_q;
  assign data_o = data_q;

endmodule

// File: rtl/shinv_ack_out.sv
module shinv_ack_out #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_line,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              req_has_data,
  input  logic [DATA_W-1:0] req_data,
  output logic              ack_valid,
  output logic [IDX_W-1:0]  ack_line,
  output logic [TAG_W-1:0]  ack_tag,
  output logic              ack_has_data,
  output logic [DATA_W-1:0] ack_data
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_valid    <= 1'b0;
      ack_line     <= '0;
      ack_tag      <= '0;
      ack_has_data <= 1'b0;
      ack_data     <= '0;
    end else begin
      ack_valid <= req_valid;
      if (req_valid) begin
        ack_line     <= req_line;
        ack_tag      <= req_tag;
        ack_has_data <= req_has_data;
        ack_data     <= req_has_data ? req_data : '0;
      end
    end
  end

endmodule

// File: rtl/shinv_handler.sv
module shinv_handler
  import shinv_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       msg_valid,
  input  logic                       msg_kind,
  input  logic [$clog2(LINES)-1:0]   msg_line,
  input  logic [TAG_W-1:0]           msg_tag,
  input  logic                       fill_valid,
  input  logic [$clog2(LINES)-1:0]   fill_line,
  input  logic                       fill_dirty,
  input  logic [DATA_W-1:0]          fill_data,
  output logic                       ack_valid,
  output logic [$clog2(LINES)-1:0]   ack_line,
  output logic [TAG_W-1:0]           ack_tag,
  output logic                       ack_has_data,
  output logic [DATA_W-1:0]          ack_data
);

  localparam int IDX_W = $clog2(LINES);

  msg_kind_e         kind;
  line_st_e          st_arr   [LINES];
  logic [DATA_W-1:0] data_arr [LINES];
  line_st_e          sel_st;
  logic [DATA_W-1:0] sel_data;

  // Named events for the checker
  logic ev_inv_mod;     // invalidation of a line holding modified data
  logic ev_inv_plain;   // invalidation answered without data
  logic ev_release;     // permission frees a waiting line
  logic ev_perm_idle;   // permission to a line that is not waiting

  assign kind = msg_kind_e'(msg_kind);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic msg_hit_g;
    logic fill_hit_g;
    assign msg_hit_g  = msg_valid  && (msg_line  == IDX_W'(g));
    assign fill_hit_g = fill_valid && (fill_line == IDX_W'(g));
    shinv_line #(.DATA_W(DATA_W)) line_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .msg_hit   (msg_hit_g),
      .msg_kind  (kind),
      .fill_hit  (fill_hit_g),
      .fill_dirty(fill_dirty),
      .fill_data (fill_data),
      .st_o      (st_arr[g]),
      .data_o    (data_arr[g])
    );
  end

  assign sel_st   = st_arr[msg_line];
  assign sel_data = data_arr[msg_line];

  assign ev_inv_mod   = msg_valid && f_acks(kind) && f_ack_carries_data(sel_st);
  assign ev_inv_plain = msg_valid && f_acks(kind) && !f_ack_carries_data(sel_st);
  assign ev_release   = msg_valid && !f_acks(kind) && (sel_st == LS_MWP);
  assign ev_perm_idle = msg_valid && !f_acks(kind) && (sel_st != LS_MWP);

  shinv_ack_out #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) ack_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (msg_valid && f_acks(kind)),
    .req_line    (msg_line),
    .req_tag     (msg_tag),
    .req_has_data(f_ack_carries_data(sel_st)),
    .req_data    (sel_data),
    .ack_valid   (ack_valid),
    .ack_line    (ack_line),
    .ack_tag     (ack_tag),
    .ack_has_data(ack_has_data),
    .ack_data    (ack_data)
  );

endmodule

// File: rtl/shinv_checker.sv
module shinv_checker #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid,
  input logic              msg_kind,
  input logic [IDX_W-1:0]  msg_line,
  input logic [TAG_W-1:0]  msg_tag,
  input logic              ack_valid,
  input logic [IDX_W-1:0]  ack_line,
  input logic [TAG_W-1:0]  ack_tag,
  input logic              ack_has_data,
  input logic [DATA_W-1:0] ack_data,
  input logic              ev_inv_mod,
  input logic              ev_inv_plain,
  input logic              ev_release,
  input logic              ev_perm_idle
);

  AST_INV_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_kind |=> ack_valid && ack_line == $past(msg_line) && ack_tag == $past(msg_tag)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> !ack_valid); // R9

  AST_MOD_DATA_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inv_mod |=> ack_valid && ack_has_data); // R4

  AST_PLAIN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inv_plain |=> ack_valid && !ack_has_data && ack_data == '0); // R2

  AST_RELEASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release |=> !ack_valid); // R6

  AST_IGNORED_PERM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_perm_idle |=> !ack_valid); // R7

  AST_DUP_SAME_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inv_mod && $past(ev_inv_mod) && msg_line == $past(msg_line) && rst_n && $past(rst_n)
    |=> ack_data == $past(ack_data)); // R5

endmodule

bind shinv_handler shinv_checker #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .msg_valid   (msg_valid),
  .msg_kind    (msg_kind),
  .msg_line    (msg_line),
  .msg_tag     (msg_tag),
  .ack_valid   (ack_valid),
  .ack_line    (ack_line),
  .ack_tag     (ack_tag),
  .ack_has_data(ack_has_data),
  .ack_data    (ack_data),
  .ev_inv_mod  (ev_inv_mod),
  .ev_inv_plain(ev_inv_plain),
  .ev_release  (ev_release),
  .ev_perm_idle(ev_perm_idle)
);

// File: tb/shinv_handler_tb.sv
module shinv_handler_tb_top;

  localparam int LINES  = 8;
  localparam int IDX_W  = 3;
  localparam int TAG_W  = 6;
  localparam int DATA_W = 32;

  // bench-side line states: 0 invalid, 1 shared, 2 modified, 3 waiting
  localparam int M_I = 0, M_S = 1, M_M = 2, M_W = 3;

  typedef struct {
    logic [IDX_W-1:0]  line;
    logic [TAG_W-1:0]  tag;
    logic              has_data;
    logic [DATA_W-1:0] data;
    string             req;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              msg_valid = 1'b0;
  logic              msg_kind = 1'b0;
  logic [IDX_W-1:0]  msg_line = '0;
  logic [TAG_W-1:0]  msg_tag = '0;
  logic              fill_valid = 1'b0;
  logic [IDX_W-1:0]  fill_line = '0;
  logic              fill_dirty = 1'b0;
  logic [DATA_W-1:0] fill_data = '0;
  logic              ack_valid;
  logic [IDX_W-1:0]  ack_line;
  logic [TAG_W-1:0]  ack_tag;
  logic              ack_has_data;
  logic [DATA_W-1:0] ack_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  exp_t sb_q[$];
  int m_st [LINES];
  logic [DATA_W-1:0] m_dat [LINES];

  always #2 clk = ~clk;   // 250 MHz

  shinv_handler #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_line(msg_line), .msg_tag(msg_tag),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_dirty(fill_dirty), .fill_data(fill_data),
    .ack_valid(ack_valid), .ack_line(ack_line), .ack_tag(ack_tag),
    .ack_has_data(ack_has_data), .ack_data(ack_data)
  );

  // One cycle of stimulus; the bench model decides what must come back.
  task automatic drive(input bit mv, input bit mk, input int ml, input int mt,
                       input bit fv, input int fl, input bit fd,
                       input logic [DATA_W-1:0] fdat, input string req);
    exp_t e;
    @(negedge clk);
    msg_valid  = mv;  msg_kind  = mk;  msg_line = IDX_W'(ml); msg_tag = TAG_W'(mt);
    fill_valid = fv;  fill_line = IDX_W'(fl); fill_dirty = fd; fill_data = fdat;
    if (mv) begin
      if (!mk) begin
        e.line = IDX_W'(ml); e.tag = TAG_W'(mt); e.req = req;
        e.has_data = (m_st[ml] == M_M) || (m_st[ml] == M_W);
        e.data     = e.has_data ? m_dat[ml] : '0;
        sb_q.push_back(e);
        if (m_st[ml] == M_S) m_st[ml] = M_I;
        if (m_st[ml] == M_M) m_st[ml] = M_W;
      end else if (m_st[ml] == M_W) begin
        m_st[ml] = M_I; m_dat[ml] = '0;
      end
    end
    if (fv && m_st[fl] == M_I && !(mv && ml == fl)) begin
      m_st[fl]  = fd ? M_M : M_S;
      m_dat[fl] = fdat;
    end
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, '0, "");
  endtask

  task automatic inv(input int l, input int t, input string req);
    drive(1, 0, l, t, 0, 0, 0, '0, req);
  endtask

  task automatic perm(input int l, input int t, input string req);
    drive(1, 1, l, t, 0, 0, 0, '0, req);
  endtask

  task automatic fill(input int l, input bit d, input logic [DATA_W-1:0] v, input string req);
    drive(0, 0, 0, 0, 1, l, d, v, req);
  endtask

  // Monitor: pops the scoreboard on every acknowledgement.
  always @(negedge clk) begin
    if (rst_n && !done && ack_valid) begin
      n_tests++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL R9: unexpected ack line=%0d tag=%0d (expected none)", ack_line, ack_tag);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (ack_line !== e.line || ack_tag !== e.tag || ack_has_data !== e.has_data || ack_data !== e.data) begin
          n_fail++;
          $display("FAIL %s: got line=%0d tag=%0d hd=%0b data=%h expected line=%0d tag=%0d hd=%0b data=%h",
                   e.req, ack_line, ack_tag, ack_has_data, ack_data, e.line, e.tag, e.has_data, e.data);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin m_st[i] = M_I; m_dat[i] = '0; end
    repeat (3) @(negedge clk);
    n_tests++;
    if (ack_valid !== 1'b0) begin
      n_fail++; $display("FAIL R1: ack_valid=%b expected 0 in reset", ack_valid);
    end
    rst_n = 1'b1;
    idle();
    n_tests++;
    if (ack_valid !== 1'b0) begin
      n_fail++; $display("FAIL R1: ack_valid=%b expected 0 after reset", ack_valid);
    end
    // R1/R3: every line starts invalid, answered with plain acks
    for (int i = 0; i < LINES; i++) inv(i, i + 1, "R1");
    idle();
    // R2 then R3 duplicate on a shared line
    fill(1, 0, 32'h1111_0001, "R8");
    inv(1, 9, "R2");
    inv(1, 9, "R3");
    idle();
    // R4, R5 on a modified line; R8 fill into waiting line dropped
    fill(2, 1, 32'hA5A5_0002, "R8");
    inv(2, 12, "R4");
    inv(2, 12, "R5");
    fill(2, 1, 32'hDEAD_BEEF, "R8");
    inv(2, 12, "R5");
    perm(2, 12, "R6");
    inv(2, 13, "R6");
    perm(2, 13, "R7");   // line now invalid: ignored
    idle();
    // R7: permission to modified and shared lines is ignored
    fill(4, 1, 32'h4444_CAFE, "R8");
    perm(4, 20, "R7");
    inv(4, 21, "R7");
    fill(3, 0, 32'h3333_0003, "R8");
    perm(3, 22, "R7");
    inv(3, 23, "R7");
    // R8: fill collides with a message to the same line
    drive(1, 0, 5, 30, 1, 5, 1, 32'h5555_5555, "R8");
    inv(5, 31, "R8");
    // R10: interleaved independent lines
    fill(6, 1, 32'h6666_0006, "R10");
    fill(7, 1, 32'h7777_0007, "R10");
    inv(6, 40, "R10");
    inv(7, 41, "R10");
    perm(6, 40, "R10");
    inv(7, 41, "R10");
    inv(6, 42, "R10");
    perm(7, 41, "R10");
    inv(7, 43, "R10");
    // R9: invalidation and fill on different lines in one cycle
    drive(1, 0, 0, 50, 1, 1, 1, 32'h0101_0101, "R9");
    inv(1, 51, "R9");
    idle();
    idle();
    n_tests++;
    if (sb_q.size() != 0) begin
      n_fail++; $display("FAIL R9: %0d acks missing, expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL R9: watchdog expired, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule